// File: doc/BRIEF.md
# FM Synthesizer Bus Write Sequencer

This block turns a register index and value, offered on a valid/ready request interface, into the two-phase write that an older FM synthesizer chip expects on its host bus. The index goes first, to the lower port address (address/status port). The value follows on the port one address above it (data port). The chip cannot take back-to-back accesses. The block therefore fills the gap after each write with dummy reads of the status port. The gap after the index write is short and the gap after the value write is long.

Client logic presents one request and waits for `req_ready`. From acceptance until the last dummy read of the long gap, the block holds `req_ready` low and `busy` high, so a second request cannot overlap the first. A one-cycle `done` pulse marks the end of each sequence. The read strobe `bus_rd` is brought out as a plain port, so other logic can observe every status-port read the sequencer makes.

Top module: `fmbus_write_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, and `busy`, `done`, `bus_cs`, `bus_wr` and `bus_rd` are 0. `bus_dout` is 0x00.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` high at a clock edge), the block drives one index write with `bus_cs`=1, `bus_wr`=1, `bus_a0`=0 and `bus_dout` equal to the accepted `req_reg`.
- R3: Directly after the index write come exactly SHORT_WAIT consecutive status reads, each one clock long, with `bus_cs`=1, `bus_rd`=1 and `bus_a0`=0. SHORT_WAIT defaults to 6.
- R4: Directly after those reads comes one value write with `bus_cs`=1, `bus_wr`=1, `bus_a0`=1 and `bus_dout` equal to the accepted `req_val`.
- R5: Directly after the value write come exactly LONG_WAIT consecutive status reads, each one clock long, with `bus_a0`=0. LONG_WAIT defaults to 35.
- R6: From the cycle after acceptance until the last long-gap read, `req_ready` is 0 and `busy` is 1. Requests and data changes in that window have no effect on the bus.
- R7: In the cycle after the last long-gap read, `done` is 1 for exactly one cycle with `req_ready` high. A request accepted in that cycle starts a new sequence at once.
- R8: `bus_rd` and `bus_wr` are never high together. `bus_cs` is high exactly when one of them is. `bus_dout` is 0x00 whenever no write is driven.
- R9: SHORT_WAIT and LONG_WAIT can be overridden (minimum 1 each). With 1 and 2, the sequence follows R2 to R7 with those counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_reg | input | 8 | Register index to write |
| req_val | input | 8 | Value to write |
| busy | output | 1 | A write sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| bus_cs | output | 1 | Chip select, high for each bus access |
| bus_a0 | output | 1 | Port select: 0 address/status port, 1 data port |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Status-read strobe |
| bus_dout | output | 8 | Write data to the chip |

## Verification
The sequencer is tried with four request patterns. A lone one-cycle request checks the basic phase order and counts. A request held high for hundreds of cycles with its data changing every cycle shows whether busy-time requests are ignored and whether the done cycle accepts the next write immediately. Random valid and data, with edge values 0x00 and 0xFF, separate the two payload bytes and detect mixed-up latching. A reset in the middle of a long gap shows that a sequence is abandoned cleanly. A second instance with gaps of 1 and 2 tells correct counter reload from counts that only happen to match the defaults.

// File: rtl/fmseq_pkg.sv
package fmseq_pkg;

  // Phases of one write sequence
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_INDEX = 3'd1,
    PH_GAP_S = 3'd2,
    PH_VALUE = 3'd3,
    PH_GAP_L = 3'd4
  } seq_ph_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/fmseq_wait_ctr.sv
// Down-counter for the dummy-read gaps; reports when the current read is the last.
module fmseq_wait_ctr #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | dec;
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/fmseq_ctrl.sv
// Phase sequencer: index write, short gap, value write, long gap.
module fmseq_ctrl
  import fmseq_pkg::*;
#(
  parameter int unsigned SHORT_WAIT = 6,
  parameter int unsigned LONG_WAIT  = 35,
  parameter int unsigned CW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          gap_last,
  output seq_ph_t       phase,
  output logic          accept,
  output logic          ctr_load,
  output logic [CW-1:0] ctr_val,
  output logic          ctr_dec,
  output logic          done
);

  localparam logic [CW-1:0] S_LOAD = CW'(SHORT_WAIT - 1);
  localparam logic [CW-1:0] L_LOAD = CW'(LONG_WAIT - 1);

  seq_ph_t ph_q, ph_d;
  logic    done_q, done_d;

  always_comb begin
    ph_d     = ph_q;
    accept   = 1'b0;
    ctr_load = 1'b0;
    ctr_val  = S_LOAD;
    ctr_dec  = 1'b0;
    done_d   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        accept = req_valid;
        if (req_valid) ph_d = PH_INDEX;
      end
      PH_INDEX: begin
        ctr_load = 1'b1;
        ctr_val  = S_LOAD;
        ph_d     = PH_GAP_S;
      end
      PH_GAP_S: begin
        ctr_dec = 1'b1;
        if (gap_last) ph_d = PH_VALUE;
      end
      PH_VALUE: begin
        ctr_load = 1'b1;
        ctr_val  = L_LOAD;
        ph_d     = PH_GAP_L;
      end
      PH_GAP_L: begin
        ctr_dec = 1'b1;
        if (gap_last) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= done_d;
    end
  end

  assign phase = ph_q;
  assign done  = done_q;

endmodule

// File: rtl/fmseq_bus_drv.sv
// Captures the payload on acceptance and decodes the bus strobes from the phase.
module fmseq_bus_drv
  import fmseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_ph_t           phase,
  input  logic              accept,
  input  logic [BYTE_W-1:0] req_reg,
  input  logic [BYTE_W-1:0] req_val,
  output logic              bus_cs,
  output logic              bus_a0,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [BYTE_W-1:0] bus_dout
);

  logic [BYTE_W-1:0] idx_q, val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      val_q <= '0;
    end else if (accept) begin
      idx_q <= req_reg;
      val_q <= req_val;
    end
  end

  always_comb begin
    bus_wr   = (phase == PH_INDEX) || (phase == PH_VALUE);
    bus_rd   = (phase == PH_GAP_S) || (phase == PH_GAP_L);
    bus_a0   = (phase == PH_VALUE);
    bus_cs   = bus_wr | bus_rd;
    bus_dout = '0;
    if (phase == PH_INDEX)      bus_dout = idx_q;
    else if (phase == PH_VALUE) bus_dout = val_q;
  end

endmodule

// File: rtl/fmbus_write_seq.sv
// Two-phase FM chip bus writer with settling gaps filled by status reads.
module fmbus_write_seq
  import fmseq_pkg::*;
#(
  parameter int unsigned SHORT_WAIT = 6,   // R3: reads after index write
  parameter int unsigned LONG_WAIT  = 35   // R5: reads after value write
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_reg,
  input  logic [7:0] req_val,
  output logic       busy,
  output logic       done,
  output logic       bus_cs,
  output logic       bus_a0,
  output logic       bus_wr,
  output logic       bus_rd,
  output logic [7:0] bus_dout
);

  localparam int unsigned MAXW = (SHORT_WAIT > LONG_WAIT) ? SHORT_WAIT : LONG_WAIT;
  localparam int unsigned CW   = (MAXW > 1) ? $clog2(MAXW) : 1;

  seq_ph_t       phase;
  logic          accept, ctr_load, ctr_dec, gap_last;
  logic [CW-1:0] ctr_val;

  fmseq_ctrl #(
    .SHORT_WAIT(SHORT_WAIT),
    .LONG_WAIT (LONG_WAIT),
    .CW        (CW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .gap_last (gap_last),
    .phase    (phase),
    .accept   (accept),
    .ctr_load (ctr_load),
    .ctr_val  (ctr_val),
    .ctr_dec  (ctr_dec),
    .done     (done)
  );

  fmseq_wait_ctr #(.CW(CW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ctr_load),
    .load_val(ctr_val),
    .dec     (ctr_dec),
    .last    (gap_last)
  );

  fmseq_bus_drv u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .accept  (accept),
    .req_reg (req_reg),
    .req_val (req_val),
    .bus_cs  (bus_cs),
    .bus_a0  (bus_a0),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .bus_dout(bus_dout)
  );

  // R6: ready only in the idle phase
  assign req_ready = (phase == PH_IDLE);
  assign busy      = ~req_ready;

endmodule

// File: rtl/fmseq_chk.sv
module fmseq_chk #(
  parameter int unsigned SHORT_WAIT = 6,
  parameter int unsigned LONG_WAIT  = 35
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_reg,
  input logic [7:0] req_val,
  input logic       busy,
  input logic       done,
  input logic       bus_cs,
  input logic       bus_a0,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_dout
);

  int unsigned rd_run;
  logic [7:0]  val_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run   <= 0;
      val_seen <= '0;
    end else begin
      if (bus_wr)      rd_run <= 0;
      else if (bus_rd) rd_run <= rd_run + 1;
      if (req_valid && req_ready) val_seen <= req_val;
    end
  end

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R8
  cs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs == (bus_rd || bus_wr));

  // R2
  index_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_wr && !bus_a0 && bus_dout == $past(req_reg)));

  // R3
  short_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_a0) |-> (rd_run == SHORT_WAIT));

  // R4
  value_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_a0) |-> (bus_dout == val_seen));

  // R5
  long_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_run == LONG_WAIT));

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && busy));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !bus_cs) ##1 !done);

endmodule

bind fmbus_write_seq fmseq_chk #(
  .SHORT_WAIT(SHORT_WAIT),
  .LONG_WAIT (LONG_WAIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_reg  (req_reg),
  .req_val  (req_val),
  .busy     (busy),
  .done     (done),
  .bus_cs   (bus_cs),
  .bus_a0   (bus_a0),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_dout (bus_dout)
);

// File: tb/sim_ref_model.sv
// Queue-based expected-cycle model: each accepted request pushes the full list
// of expected bus cycles; one entry is consumed per clock.
// Tags: R2 index write, R3 short reads, R4 value write, R5 long reads,
// R6 ready/busy, R7 done cycle, R8 quiet bus when idle, R9 overridden counts.
module sim_ref_model #(
  parameter int    S  = 6,
  parameter int    L  = 35,
  parameter string ID = "u0"
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_reg,
  input  logic [7:0] req_val,
  input  logic       req_ready,
  input  logic       busy,
  input  logic       done,
  input  logic       bus_cs,
  input  logic       bus_a0,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_dout,
  output int         n_chk,
  output int         n_fail
);

  typedef struct {
    bit       dn, bsy, cs, a0, wr, rd;
    bit [7:0] d;
    int       tag;
  } ent_t;

  ent_t q[$];

  initial begin
    n_chk  = 0;
    n_fail = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
    end else begin
      bit acc;
      acc = req_valid && (q.size() == 0 || !q[0].bsy);
      if (q.size() > 0) void'(q.pop_front());
      if (acc) begin
        q.push_back('{dn:0, bsy:1, cs:1, a0:0, wr:1, rd:0, d:req_reg, tag:2});
        for (int i = 0; i < S; i++)
          q.push_back('{dn:0, bsy:1, cs:1, a0:0, wr:0, rd:1, d:8'h00, tag:3});
        q.push_back('{dn:0, bsy:1, cs:1, a0:1, wr:1, rd:0, d:req_val, tag:4});
        for (int i = 0; i < L; i++)
          q.push_back('{dn:0, bsy:1, cs:1, a0:0, wr:0, rd:1, d:8'h00, tag:5});
        q.push_back('{dn:1, bsy:0, cs:0, a0:0, wr:0, rd:0, d:8'h00, tag:7});
      end
    end
  end

  task automatic cmp(input int tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d [%s] %s actual=%0h expected=%0h at %0t", tag, ID, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      ent_t e;
      if (q.size() > 0) e = q[0];
      else e = '{dn:0, bsy:0, cs:0, a0:0, wr:0, rd:0, d:8'h00, tag:8};
      cmp(6, "req_ready", req_ready, !e.bsy);
      cmp(6, "busy", busy, e.bsy);
      cmp(7, "done", done, e.dn);
      cmp(e.tag, "bus_cs", bus_cs, e.cs);
      cmp(e.tag, "bus_wr", bus_wr, e.wr);
      cmp(e.tag, "bus_rd", bus_rd, e.rd);
      if (e.cs) cmp(e.tag, "bus_a0", bus_a0, e.a0);
      cmp(e.tag, "bus_dout", bus_dout, e.d);
    end
  end

endmodule

// File: tb/sim_fmbus_write_seq.sv
module sim_fmbus_write_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_reg = 8'h00;
  logic [7:0] req_val = 8'h00;

  logic       rdy0, bsy0, dn0, cs0, a00, wr0, rd0;
  logic [7:0] do0;
  logic       rdy1, bsy1, dn1, cs1, a01, wr1, rd1;
  logic [7:0] do1;

  int m0_chk, m0_fail, m1_chk, m1_fail;
  int t_chk = 0, t_fail = 0;
  int cyc = 0;
  bit ended = 0;

  always #4 clk = ~clk;  // 125 MHz

  fmbus_write_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
    .req_reg(req_reg), .req_val(req_val), .busy(bsy0), .done(dn0),
    .bus_cs(cs0), .bus_a0(a00), .bus_wr(wr0), .bus_rd(rd0), .bus_dout(do0)
  );

  // R9: overridden gap counts
  fmbus_write_seq #(.SHORT_WAIT(1), .LONG_WAIT(2)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
    .req_reg(req_reg), .req_val(req_val), .busy(bsy1), .done(dn1),
    .bus_cs(cs1), .bus_a0(a01), .bus_wr(wr1), .bus_rd(rd1), .bus_dout(do1)
  );

  sim_ref_model #(.S(6), .L(35), .ID("u0")) m0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_reg(req_reg), .req_val(req_val),
    .req_ready(rdy0), .busy(bsy0), .done(dn0), .bus_cs(cs0), .bus_a0(a00),
    .bus_wr(wr0), .bus_rd(rd0), .bus_dout(do0), .n_chk(m0_chk), .n_fail(m0_fail)
  );

  sim_ref_model #(.S(1), .L(2), .ID("u1 R9")) m1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_reg(req_reg), .req_val(req_val),
    .req_ready(rdy1), .busy(bsy1), .done(dn1), .bus_cs(cs1), .bus_a0(a01),
    .bus_wr(wr1), .bus_rd(rd1), .bus_dout(do1), .n_chk(m1_chk), .n_fail(m1_fail)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    t_chk++;
    if (act != exp) begin
      t_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               t_chk + m0_chk + m1_chk, t_fail + m0_fail + m1_fail);
      $finish;
    end
  endtask

  // R1: idle state of both instances
  task automatic check_idle();
    check("R1", "u0 ready", rdy0, 1);
    check("R1", "u0 busy", bsy0, 0);
    check("R1", "u0 done", dn0, 0);
    check("R1", "u0 cs/wr/rd", {cs0, wr0, rd0}, 0);
    check("R1", "u0 dout", do0, 0);
    check("R1", "u1 ready", rdy1, 1);
    check("R1", "u1 cs", cs1, 0);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      t_chk++;
      t_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_up();
    end
  end

  initial begin
    // R1: during reset
    idle_cycles(3);
    check_idle();
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_idle();

    // Lone one-cycle request (R2, R3, R4, R5, R7)
    req_valid = 1'b1; req_reg = 8'h12; req_val = 8'h34;
    @(negedge clk);
    req_valid = 1'b0; req_reg = 8'hEE; req_val = 8'hDD;
    // R2: index write in the cycle after acceptance, payload captured at acceptance
    check("R2", "u0 index dout", do0, 8'h12);
    check("R2", "u0 index wr/a0", {wr0, a00}, 2'b10);
    idle_cycles(6);
    @(negedge clk);
    // R4: value write after exactly 6 reads
    check("R4", "u0 value wr/a0", {wr0, a00}, 2'b11);
    check("R4", "u0 value dout", do0, 8'h34);
    idle_cycles(50);

    // Held request with changing data: busy-time changes ignored (R6),
    // done-cycle acceptance back to back (R7)
    req_valid = 1'b1;
    for (int i = 0; i < 300; i++) begin
      req_reg = 8'(i * 7);
      req_val = 8'(255 - i);
      @(negedge clk);
    end
    req_valid = 1'b0;
    idle_cycles(50);

    // Random valid and data, with edge values 0x00 and 0xFF
    for (int i = 0; i < 1500; i++) begin
      req_valid = ($urandom % 4) == 0;
      case ($urandom % 4)
        0: begin req_reg = 8'h00; req_val = 8'hFF; end
        1: begin req_reg = 8'hFF; req_val = 8'h00; end
        default: begin req_reg = 8'($urandom); req_val = 8'($urandom); end
      endcase
      @(negedge clk);
    end
    req_valid = 1'b0;
    idle_cycles(50);

    // Reset in the middle of a long gap (R1)
    req_valid = 1'b1; req_reg = 8'hA5; req_val = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0;
    idle_cycles(15);
    #1 rst_n = 1'b0;
    @(negedge clk);
    check_idle();
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_idle();

    // One more write after reset
    req_valid = 1'b1; req_reg = 8'h0F; req_val = 8'hF0;
    @(negedge clk);
    req_valid = 1'b0;
    idle_cycles(60);
    check("R7", "u0 back to idle", rdy0, 1);

    finish_up();
  end

endmodule